// File: doc/BRIEF.md
# FIFO Trigger Level Selector

This block decides when a serial port's transmit and receive FIFOs have reached the point where an interrupt or DMA request should be raised. It holds one 8-bit threshold register split into two 4-bit fields. The low field sets the transmit threshold as a count of free slots in the transmit FIFO. The high field sets the receive threshold as a count of characters waiting in the receive FIFO. A nonzero field value N gives a threshold of 8·N. A field left at zero hands that direction back to a coarse legacy threshold, picked by a 2-bit code from the FIFO control logic.

The surrounding logic supplies the live FIFO counts, the two legacy codes and a register write port. The write port only takes effect while two enable bits, one for enhanced features and one for mode control, are both set. The block returns one registered trigger flag per direction. FIFO storage and interrupt prioritisation belong to other blocks.

Top module: `fifo_trig_sel`

## Requirements
- R1: While reset is asserted, both trigger outputs are 0. Reset clears the threshold register to 0, so after reset both directions use their legacy thresholds.
- R2: `cfg_wr_en` loads `cfg_wr_data` into the threshold register only when `feat_en` and `mode_en` are both 1. Otherwise the write is ignored and the register keeps its value.
- R3: When register bits 3:0 hold a nonzero value N, the transmit threshold is 8·N free slots (8 to 120).
- R4: When register bits 7:4 hold a nonzero value N, the receive threshold is 8·N characters (8 to 120).
- R5: When bits 3:0 are zero, the transmit threshold follows `tx_legacy_sel`: code 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 56.
- R6: When bits 7:4 are zero, the receive threshold follows `rx_legacy_sel`: code 0 gives 1, 1 gives 16, 2 gives 32 and 3 gives 56.
- R7: `tx_trigger` is 1 exactly when `tx_space` is at least the transmit threshold. `rx_trigger` is 1 exactly when `rx_fill` is at least the receive threshold.
- R8: Each trigger output is a register. It shows the comparison of the counts, legacy codes and threshold register as they stood before the preceding rising clock edge. A register write therefore first shows on the outputs one edge after it is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_space | input | CNT_W | Free slots in the transmit FIFO |
| rx_fill | input | CNT_W | Characters held in the receive FIFO |
| cfg_wr_en | input | 1 | Write strobe for the threshold register |
| cfg_wr_data | input | 2*FIELD_W | Write data: [3:0] transmit field, [7:4] receive field |
| feat_en | input | 1 | Enhanced-features enable, required for a write |
| mode_en | input | 1 | Mode-control enable, required for a write |
| tx_legacy_sel | input | 2 | Legacy transmit threshold code |
| rx_legacy_sel | input | 2 | Legacy receive threshold code |
| tx_trigger | output | 1 | Transmit free space at or above threshold |
| rx_trigger | output | 1 | Receive fill at or above threshold |

## Verification
The bench drives counts one below and exactly at every legacy threshold and at the programmed extremes of 8 and 120. A design off by one in its comparison, or one that scales the field wrongly, fails at these points. The bench also tries writes with only one of the two enables set. A design that ignores half the gate loses the legacy fallback, which shows when a fill of 1 no longer raises the receive trigger. Finally, the bench rewrites the register while the counts stay fixed. This catches a design that applies a new threshold one cycle early or one cycle late. Random counts, codes and gated writes then cover the mix of programmed and fallback fields.

// File: rtl/fifo_trig_pkg.sv
package fifo_trig_pkg;
   // a field value N encodes a level of N << STEP_SHIFT
   localparam int STEP_SHIFT = 3;
   localparam int DIR_TX = 0;
   localparam int DIR_RX = 1;
   localparam int NUM_DIR = 2;
   // coarse fallback levels, indexed by the 2-bit select code
   localparam int RX_LEG0 = 1;
   localparam int TX_LEG0 = 8;
   localparam int LEG1 = 16;
   localparam int LEG2 = 32;
   localparam int LEG3 = 56;
   localparam int MAX_LEGACY = LEG3;
endpackage

// File: rtl/fifo_trig_cfg_reg.sv
module fifo_trig_cfg_reg #(
   parameter int FIELD_W = 4,
   localparam int REG_W = 2 * FIELD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             feat_en,
   input  logic             mode_en,
   output logic [REG_W-1:0] cfg_q
);
   logic wr_ok;
   assign wr_ok = wr_en && feat_en && mode_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cfg_q <= '0;
      else if (wr_ok) cfg_q <= wr_data;
   end
endmodule

// File: rtl/fifo_trig_level.sv
module fifo_trig_level #(
   parameter int FIELD_W = 4,
   parameter int CNT_W = 8,
   parameter bit IS_RX = 1'b0
) (
   input  logic [FIELD_W-1:0] field,
   input  logic [1:0]         legacy_sel,
   output logic [CNT_W-1:0]   level
);
   import fifo_trig_pkg::*;

   logic [CNT_W-1:0] legacy_lvl;
   logic [CNT_W-1:0] prog_lvl;

   generate
      if (IS_RX) begin : g_rx_table
         always_comb begin
            unique case (legacy_sel)
               2'd0: legacy_lvl = CNT_W'(RX_LEG0);
               2'd1: legacy_lvl = CNT_W'(LEG1);
               2'd2: legacy_lvl = CNT_W'(LEG2);
               default: legacy_lvl = CNT_W'(LEG3);
            endcase
         end
      end else begin : g_tx_table
         always_comb begin
            unique case (legacy_sel)
               2'd0: legacy_lvl = CNT_W'(TX_LEG0);
               2'd1: legacy_lvl = CNT_W'(LEG1);
               2'd2: legacy_lvl = CNT_W'(LEG2);
               default: legacy_lvl = CNT_W'(LEG3);
            endcase
         end
      end
   endgenerate

   assign prog_lvl = CNT_W'(field) << STEP_SHIFT;
   assign level = (field == '0) ? legacy_lvl : prog_lvl;
endmodule

// File: rtl/fifo_trig_cmp.sv
module fifo_trig_cmp #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] level,
   output logic             hit
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit <= 1'b0;
      else        hit <= (count >= level);
   end
endmodule

// File: rtl/fifo_trig_sel.sv
module fifo_trig_sel #(
   parameter int FIELD_W = 4,
   parameter int CNT_W = 8,
   localparam int REG_W = 2 * FIELD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] tx_space,
   input  logic [CNT_W-1:0] rx_fill,
   input  logic             cfg_wr_en,
   input  logic [REG_W-1:0] cfg_wr_data,
   input  logic             feat_en,
   input  logic             mode_en,
   input  logic [1:0]       tx_legacy_sel,
   input  logic [1:0]       rx_legacy_sel,
   output logic             tx_trigger,
   output logic             rx_trigger
);
   import fifo_trig_pkg::*;

   localparam int MIN_CNT_W = FIELD_W + STEP_SHIFT;

   generate
      if (FIELD_W < 1) begin : g_bad_field
         $error("fifo_trig_sel: FIELD_W must be at least 1");
      end
      if (CNT_W < MIN_CNT_W || (2 ** CNT_W) <= MAX_LEGACY) begin : g_bad_cnt
         $error("fifo_trig_sel: CNT_W too narrow for the largest level");
      end
   endgenerate

   logic [REG_W-1:0] cfg_q;
   logic [CNT_W-1:0] tx_level;
   logic [CNT_W-1:0] rx_level;

   logic [NUM_DIR-1:0][CNT_W-1:0]   dir_cnt;
   logic [NUM_DIR-1:0][CNT_W-1:0]   dir_lvl;
   logic [NUM_DIR-1:0][FIELD_W-1:0] dir_field;
   logic [NUM_DIR-1:0][1:0]         dir_sel;
   logic [NUM_DIR-1:0]              dir_hit;

   fifo_trig_cfg_reg #(.FIELD_W(FIELD_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr_en),
      .wr_data (cfg_wr_data),
      .feat_en (feat_en),
      .mode_en (mode_en),
      .cfg_q   (cfg_q)
   );

   assign dir_cnt[DIR_TX]   = tx_space;
   assign dir_cnt[DIR_RX]   = rx_fill;
   assign dir_field[DIR_TX] = cfg_q[FIELD_W-1:0];
   assign dir_field[DIR_RX] = cfg_q[REG_W-1:FIELD_W];
   assign dir_sel[DIR_TX]   = tx_legacy_sel;
   assign dir_sel[DIR_RX]   = rx_legacy_sel;

   for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
      fifo_trig_level #(
         .FIELD_W (FIELD_W),
         .CNT_W   (CNT_W),
         .IS_RX   (d == DIR_RX)
      ) u_level (
         .field      (dir_field[d]),
         .legacy_sel (dir_sel[d]),
         .level      (dir_lvl[d])
      );

      fifo_trig_cmp #(.CNT_W(CNT_W)) u_cmp (
         .clk   (clk),
         .rst_n (rst_n),
         .count (dir_cnt[d]),
         .level (dir_lvl[d]),
         .hit   (dir_hit[d])
      );
   end

   assign tx_level   = dir_lvl[DIR_TX];
   assign rx_level   = dir_lvl[DIR_RX];
   assign tx_trigger = dir_hit[DIR_TX];
   assign rx_trigger = dir_hit[DIR_RX];
endmodule

// File: rtl/fifo_trig_chk.sv
module fifo_trig_chk #(
   parameter int FIELD_W = 4,
   parameter int CNT_W = 8,
   localparam int REG_W = 2 * FIELD_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             feat_en,
   input logic             mode_en,
   input logic [REG_W-1:0] cfg_q,
   input logic [CNT_W-1:0] tx_level,
   input logic [CNT_W-1:0] rx_level,
   input logic [CNT_W-1:0] tx_space,
   input logic [CNT_W-1:0] rx_fill,
   input logic             tx_trigger,
   input logic             rx_trigger
);
   // R2: the register cannot move unless both enables are set
   p_wr_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(feat_en && mode_en) |=> $stable(cfg_q));

   // R3: a programmed transmit field scales by eight
   p_tx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[FIELD_W-1:0] != '0) |-> (tx_level == CNT_W'(cfg_q[FIELD_W-1:0]) * CNT_W'(8)));

   // R4: a programmed receive field scales by eight
   p_rx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[REG_W-1:FIELD_W] != '0) |-> (rx_level == CNT_W'(cfg_q[REG_W-1:FIELD_W]) * CNT_W'(8)));

   // R5: a zero transmit field gives one of the transmit fallback levels
   p_tx_legacy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[FIELD_W-1:0] == '0) |-> (tx_level inside {8, 16, 32, 56}));

   // R6: a zero receive field gives one of the receive fallback levels
   p_rx_legacy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[REG_W-1:FIELD_W] == '0) |-> (rx_level inside {1, 16, 32, 56}));

   // R7 and R8: the flag follows the comparison one edge later
   p_tx_cmp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (tx_trigger == $past(tx_space >= tx_level)));

   p_rx_cmp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (rx_trigger == $past(rx_fill >= rx_level)));
endmodule

bind fifo_trig_sel fifo_trig_chk #(.FIELD_W(FIELD_W), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .feat_en    (feat_en),
   .mode_en    (mode_en),
   .cfg_q      (cfg_q),
   .tx_level   (tx_level),
   .rx_level   (rx_level),
   .tx_space   (tx_space),
   .rx_fill    (rx_fill),
   .tx_trigger (tx_trigger),
   .rx_trigger (rx_trigger)
);

// File: tb/fifo_trig_sel_bench.sv
module fifo_trig_sel_bench;
   localparam int FIELD_W = 4;
   localparam int CNT_W = 8;
   localparam int WATCHDOG_CYC = 150000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [CNT_W-1:0] tx_space = '0;
   logic [CNT_W-1:0] rx_fill = '0;
   logic             cfg_wr_en = 1'b0;
   logic [7:0]       cfg_wr_data = '0;
   logic             feat_en = 1'b0;
   logic             mode_en = 1'b0;
   logic [1:0]       tx_legacy_sel = '0;
   logic [1:0]       rx_legacy_sel = '0;
   logic             tx_trigger;
   logic             rx_trigger;

   int nchk = 0;
   int nerr = 0;
   logic [7:0] model_cfg = '0;

   always #4 clk = ~clk;

   fifo_trig_sel #(.FIELD_W(FIELD_W), .CNT_W(CNT_W)) u_fifo_trig_sel (
      .clk           (clk),
      .rst_n         (rst_n),
      .tx_space      (tx_space),
      .rx_fill       (rx_fill),
      .cfg_wr_en     (cfg_wr_en),
      .cfg_wr_data   (cfg_wr_data),
      .feat_en       (feat_en),
      .mode_en       (mode_en),
      .tx_legacy_sel (tx_legacy_sel),
      .rx_legacy_sel (rx_legacy_sel),
      .tx_trigger    (tx_trigger),
      .rx_trigger    (rx_trigger)
   );

   function automatic int ref_level(input logic [3:0] field, input logic [1:0] sel, input bit is_rx);
      if (field != 4'd0) return int'(field) * 8;
      case (sel)
         2'd0: return is_rx ? 1 : 8;
         2'd1: return 16;
         2'd2: return 32;
         default: return 56;
      endcase
   endfunction

   task automatic check(input string tag, input string what, input logic act, input logic exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   // drive one cycle of inputs at a falling edge; check the outputs after the next rising edge
   task automatic cyc(input int ts, input int rf, input bit we, input logic [7:0] wd,
                      input bit fe, input bit me, input logic [1:0] tsel, input logic [1:0] rsel,
                      input string tag);
      logic exp_tx, exp_rx;
      tx_space = CNT_W'(ts);
      rx_fill = CNT_W'(rf);
      cfg_wr_en = we;
      cfg_wr_data = wd;
      feat_en = fe;
      mode_en = me;
      tx_legacy_sel = tsel;
      rx_legacy_sel = rsel;
      exp_tx = (ts >= ref_level(model_cfg[3:0], tsel, 1'b0));
      exp_rx = (rf >= ref_level(model_cfg[7:4], rsel, 1'b1));
      if (we && fe && me) model_cfg = wd;
      @(posedge clk);
      @(negedge clk);
      check(tag, "tx_trigger", tx_trigger, exp_tx);
      check(tag, "rx_trigger", rx_trigger, exp_rx);
   endtask

   task automatic wr(input logic [7:0] wd, input string tag);
      cyc(0, 0, 1'b1, wd, 1'b1, 1'b1, 2'd0, 2'd0, tag);
   endtask

   initial begin
      repeat (WATCHDOG_CYC) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG_CYC);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      int lv;
      void'($urandom(32'h5eed_1234));
      // R1: triggers held low during reset even with full counts
      tx_space = 8'd200;
      rx_fill = 8'd200;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", "tx_trigger in reset", tx_trigger, 1'b0);
      check("R1", "rx_trigger in reset", rx_trigger, 1'b0);
      rst_n = 1'b1;

      // R1: cleared register means fallback levels (tx 8, rx 1)
      cyc(8, 0, 0, 8'h00, 0, 0, 2'd0, 2'd0, "R1");
      cyc(7, 1, 0, 8'h00, 0, 0, 2'd0, 2'd0, "R1");

      // R2: writes with only one enable, or none, are ignored
      cyc(0, 0, 1, 8'hFF, 1, 0, 2'd0, 2'd0, "R2");
      cyc(8, 1, 0, 8'h00, 0, 0, 2'd0, 2'd0, "R2");
      cyc(0, 0, 1, 8'hFF, 0, 1, 2'd0, 2'd0, "R2");
      cyc(8, 1, 0, 8'h00, 0, 0, 2'd0, 2'd0, "R2");
      cyc(0, 0, 1, 8'hFF, 0, 0, 2'd0, 2'd0, "R2");
      cyc(8, 1, 0, 8'h00, 0, 0, 2'd0, 2'd0, "R2");

      // R5, R6: each legacy code, one below and at the level
      for (int s = 0; s < 4; s++) begin
         lv = ref_level(4'd0, 2'(s), 1'b0);
         cyc(lv - 1, 0, 0, 8'h00, 0, 0, 2'(s), 2'd3, "R5");
         cyc(lv, 0, 0, 8'h00, 0, 0, 2'(s), 2'd3, "R5");
         lv = ref_level(4'd0, 2'(s), 1'b1);
         cyc(0, lv - 1, 0, 8'h00, 0, 0, 2'd3, 2'(s), "R6");
         cyc(0, lv, 0, 8'h00, 0, 0, 2'd3, 2'(s), "R6");
      end

      // R3: transmit field at maximum (120), receive still legacy
      wr(8'h0F, "R3");
      cyc(119, 1, 0, 8'h00, 0, 0, 2'd0, 2'd0, "R3");
      cyc(120, 1, 0, 8'h00, 0, 0, 2'd0, 2'd0, "R3");
      wr(8'h01, "R3");
      cyc(7, 0, 0, 8'h00, 0, 0, 2'd3, 2'd0, "R3");
      cyc(8, 0, 0, 8'h00, 0, 0, 2'd3, 2'd0, "R3");

      // R4: receive field at minimum (8) and maximum (120)
      wr(8'h10, "R4");
      cyc(0, 7, 0, 8'h00, 0, 0, 2'd0, 2'd0, "R4");
      cyc(0, 8, 0, 8'h00, 0, 0, 2'd0, 2'd0, "R4");
      wr(8'hF0, "R4");
      cyc(0, 119, 0, 8'h00, 0, 0, 2'd0, 2'd0, "R4");
      cyc(0, 120, 0, 8'h00, 0, 0, 2'd0, 2'd0, "R4");
      cyc(255, 255, 0, 8'h00, 0, 0, 2'd0, 2'd0, "R7");

      // R8: a write takes effect on the outputs one edge after it is stored
      wr(8'h02, "R8");
      cyc(16, 0, 0, 8'h00, 0, 0, 2'd0, 2'd0, "R8");
      cyc(16, 0, 1, 8'h03, 1, 1, 2'd0, 2'd0, "R8");
      cyc(16, 0, 0, 8'h00, 0, 0, 2'd0, 2'd0, "R8");

      // R7: random counts, codes and gated writes
      for (int i = 0; i < 3000; i++) begin
         logic [7:0] d;
         int ts, rf;
         d = 8'($urandom);
         if ($urandom_range(3) == 0) d[3:0] = 4'd0;
         if ($urandom_range(3) == 0) d[7:4] = 4'd0;
         ts = ($urandom_range(7) == 0) ? int'($urandom_range(255)) : int'($urandom_range(130));
         rf = ($urandom_range(7) == 0) ? int'($urandom_range(255)) : int'($urandom_range(130));
         cyc(ts, rf, ($urandom_range(4) == 0), d,
             ($urandom_range(3) != 0), ($urandom_range(3) != 0),
             2'($urandom_range(3)), 2'($urandom_range(3)), "R7");
      end

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule